// File: doc/BRIEF.md
# Tick-Driven Countdown Timer Bank

This block holds a set of identical countdown channels, one intended for each processor core. The channels advance only on cycles where a shared tick strobe is high; the strobe is expected to pulse once per microsecond. Each channel has two 32-bit registers, reached through a simple write/read port. Channel k uses byte address `BASE_OFF + 8*k` for its preset/control word and `BASE_OFF + 8*k + 4` for its status/clear word.

Software writes a count together with an enable flag and a repeat flag. A loaded count N makes the channel expire on the (N+1)-th tick. On expiry the channel sets a pending flag, which drives that channel's active-high, level-sensitive interrupt line. In repeat mode the count reloads and the channel keeps running. In single mode the enable flag drops by itself. Software acknowledges the interrupt by writing the clear bit in the status word.

Top module: `tick_cdt_bank`

## Requirements
- R1: After reset every interrupt line is low and every channel's preset and status words read as zero.
- R2: A write to a channel's preset word takes effect at once. Bit 31 enables the channel, bit 30 selects repeat mode and bits 28:0 are the load value. The count restarts from the new load value even while the channel is running, and a tick in the same cycle is ignored.
- R3: With load value N, the interrupt stays low after N ticks and is high in the cycle after the (N+1)-th tick. N = 0 expires on the first tick.
- R4: In repeat mode (bit 30 = 1), expiry reloads the count with the load value and the channel stays enabled, so it expires again every N+1 ticks.
- R5: In single mode (bit 30 = 0), expiry clears the enable flag (bit 31 of the preset word reads 0), and no further interrupt occurs without a new write.
- R6: Writing 0 to the preset word stops the channel: the count reads 0, stays there, and no interrupt is raised by later ticks.
- R7: Writing the status word with bit 30 = 1 clears the pending interrupt. Writing it with bit 30 = 0 leaves the interrupt unchanged.
- R8: If an expiry and a clear write fall in the same cycle, the interrupt remains pending.
- R9: Reading the status word returns the current count in bits 28:0 and the pending flag in bit 30, with all other bits 0.
- R10: On cycles without a tick strobe the count holds its value.
- R11: Once raised, the interrupt line stays high until it is cleared.
- R12: Writes to addresses that map to no register change no channel state, and reads from such addresses return 0. This covers addresses outside the bank and offsets inside a stride other than 0 and 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Tick strobe; channels advance on cycles where it is high |
| bus_we_i | input | 1 | Register write enable |
| bus_addr_i | input | ADDR_W | Byte address for writes and reads |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i (combinational) |
| irq_o | output | NUM_CH | One active-high level interrupt per channel |

## Verification
A table of load values is driven across different channels in both modes: 0, 1, 2, 5 and 13. It measures the exact tick on which each channel expires. This separates an N+1 count from an N or N+2 count, and shows that the first tick is honoured when N is 0. Directed patterns follow.
- A rewrite while running shows that the count restarts rather than resumes.
- A repeat sequence shows the reload.
- A single-shot sequence shows that the enable drops and that no second expiry follows.
- A tick together with a clear, both at the moment of expiry and away from it, shows which of the two takes priority.
- Writes to gaps in the map and outside it, made while other channels hold known counts, show that the decoder cannot corrupt a neighbour.

// File: rtl/tick_cdt_pkg.sv
package tick_cdt_pkg;
   localparam int REG_W     = 32;
   localparam int ENA_BIT   = 31;
   localparam int REP_BIT   = 30;
   localparam int ACK_BIT   = 30;
   localparam int PEND_BIT  = 30;
   localparam int PRESET_WORD = 0;
   localparam int STATUS_WORD = 4;

   typedef enum logic [1:0] {
      SEL_NONE   = 2'd0,
      SEL_PRESET = 2'd1,
      SEL_STATUS = 2'd2
   } reg_sel_e;
endpackage

// File: rtl/tick_cdt_decode.sv
module tick_cdt_decode
   import tick_cdt_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int NUM_CH    = 4,
   parameter int BASE_OFF  = 'h50,
   parameter int CH_STRIDE = 8
) (
   input  logic [ADDR_W-1:0] addr_i,
   output logic [NUM_CH-1:0] ch_sel_o,
   output reg_sel_e          reg_sel_o
);
   localparam int SH    = $clog2(CH_STRIDE);
   localparam int IDX_W = ADDR_W + 1 - SH;
   localparam logic [ADDR_W:0] BASE_X = (ADDR_W+1)'(BASE_OFF);
   localparam logic [ADDR_W:0] SPAN_X = (ADDR_W+1)'(NUM_CH * CH_STRIDE);

   logic [ADDR_W:0]  off;
   logic             in_rng;
   logic [SH-1:0]    word;
   logic [IDX_W-1:0] idx;

   always_comb begin
      off    = {1'b0, addr_i} - BASE_X;
      in_rng = ({1'b0, addr_i} >= BASE_X) && (off < SPAN_X);
      word   = off[SH-1:0];
      idx    = off[ADDR_W:SH];
   end

   for (genvar k = 0; k < NUM_CH; k++) begin : g_sel
      assign ch_sel_o[k] = in_rng && (idx == IDX_W'(k));
   end

   always_comb begin
      reg_sel_o = SEL_NONE;
      if (in_rng) begin
         if (word == SH'(PRESET_WORD))      reg_sel_o = SEL_PRESET;
         else if (word == SH'(STATUS_WORD)) reg_sel_o = SEL_STATUS;
      end
   end

   // R12: at most one channel is selected by any address
   always_comb begin
      assert_one_channel_R12: assert ($onehot0(ch_sel_o));
   end
endmodule

// File: rtl/tick_cdt_channel.sv
module tick_cdt_channel
   import tick_cdt_pkg::*;
#(
   parameter int CNT_W = 29
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             pre_wr_i,
   input  logic             clr_wr_i,
   input  logic [REG_W-1:0] wdata_i,
   output logic [REG_W-1:0] preset_word_o,
   output logic [REG_W-1:0] status_word_o,
   output logic             irq_o
);
   localparam int PAD_W = 30 - CNT_W;

   logic             ena_q, rep_q, pend_q;
   logic [CNT_W-1:0] load_q, cnt_q;
   logic             at_zero, expire, ack;

   assign at_zero = (cnt_q == '0);
   assign expire  = ena_q && tick_i && at_zero && !pre_wr_i;
   assign ack     = clr_wr_i && wdata_i[ACK_BIT];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ena_q  <= 1'b0;
         rep_q  <= 1'b0;
         load_q <= '0;
         cnt_q  <= '0;
      end else if (pre_wr_i) begin
         ena_q  <= wdata_i[ENA_BIT];
         rep_q  <= wdata_i[REP_BIT];
         load_q <= wdata_i[CNT_W-1:0];
         cnt_q  <= wdata_i[CNT_W-1:0];
      end else if (ena_q && tick_i) begin
         if (at_zero) begin
            if (rep_q) cnt_q <= load_q;
            else       ena_q <= 1'b0;
         end else begin
            cnt_q <= cnt_q - 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      pend_q <= 1'b0;
      else if (expire) pend_q <= 1'b1;
      else if (ack)    pend_q <= 1'b0;
   end

   assign preset_word_o = {ena_q, rep_q, {PAD_W{1'b0}}, load_q};
   assign status_word_o = {1'b0, pend_q, {PAD_W{1'b0}}, cnt_q};
   assign irq_o         = pend_q;

   assert_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
      pre_wr_i |=> (cnt_q == $past(wdata_i[CNT_W-1:0])));
   assert_expire_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ena_q && tick_i && at_zero && !pre_wr_i) |=> irq_o);
   assert_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ena_q && rep_q && tick_i && at_zero && !pre_wr_i) |=> (ena_q && cnt_q == $past(load_q)));
   assert_single_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ena_q && !rep_q && tick_i && at_zero && !pre_wr_i) |=> !ena_q);
   assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_i && !pre_wr_i) |=> $stable(cnt_q));
   assert_irq_level_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && !ack) |=> irq_o);
   assert_expire_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && ena_q && tick_i && at_zero && !pre_wr_i) |=> irq_o);
endmodule

// File: rtl/tick_cdt_rdmux.sv
module tick_cdt_rdmux
   import tick_cdt_pkg::*;
#(
   parameter int NUM_CH = 4
) (
   input  logic [NUM_CH-1:0]       ch_sel_i,
   input  reg_sel_e                reg_sel_i,
   input  logic [NUM_CH*REG_W-1:0] preset_words_i,
   input  logic [NUM_CH*REG_W-1:0] status_words_i,
   output logic [REG_W-1:0]        rdata_o
);
   always_comb begin
      rdata_o = '0;
      for (int k = 0; k < NUM_CH; k++) begin
         if (ch_sel_i[k]) begin
            if (reg_sel_i == SEL_PRESET)      rdata_o = rdata_o | preset_words_i[k*REG_W +: REG_W];
            else if (reg_sel_i == SEL_STATUS) rdata_o = rdata_o | status_words_i[k*REG_W +: REG_W];
         end
      end
   end
endmodule

// File: rtl/tick_cdt_bank.sv
module tick_cdt_bank
   import tick_cdt_pkg::*;
#(
   parameter int NUM_CH    = 4,
   parameter int CNT_W     = 29,
   parameter int ADDR_W    = 8,
   parameter int BASE_OFF  = 'h50,
   parameter int CH_STRIDE = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              bus_we_i,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic [REG_W-1:0]  bus_wdata_i,
   output logic [REG_W-1:0]  bus_rdata_o,
   output logic [NUM_CH-1:0] irq_o
);
   localparam int SPAN = NUM_CH * CH_STRIDE;

   if (NUM_CH < 1) begin : g_bad_nch
      $error("NUM_CH must be at least 1");
   end
   if (CNT_W < 1 || CNT_W > 29) begin : g_bad_cnt
      $error("CNT_W must lie in 1..29");
   end
   if (CH_STRIDE < 8 || (CH_STRIDE & (CH_STRIDE - 1)) != 0) begin : g_bad_stride
      $error("CH_STRIDE must be a power of two, at least 8");
   end
   if (BASE_OFF + SPAN > (1 << ADDR_W)) begin : g_bad_map
      $error("register bank does not fit in ADDR_W");
   end

   logic [NUM_CH-1:0]       ch_sel;
   reg_sel_e                reg_sel;
   logic [NUM_CH*REG_W-1:0] preset_words, status_words;

   tick_cdt_decode #(
      .ADDR_W(ADDR_W), .NUM_CH(NUM_CH), .BASE_OFF(BASE_OFF), .CH_STRIDE(CH_STRIDE)
   ) u_decode (
      .addr_i(bus_addr_i), .ch_sel_o(ch_sel), .reg_sel_o(reg_sel)
   );

   for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
      logic pre_wr, clr_wr;
      assign pre_wr = bus_we_i && ch_sel[k] && (reg_sel == SEL_PRESET);
      assign clr_wr = bus_we_i && ch_sel[k] && (reg_sel == SEL_STATUS);

      tick_cdt_channel #(.CNT_W(CNT_W)) u_ch (
         .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
         .pre_wr_i(pre_wr), .clr_wr_i(clr_wr), .wdata_i(bus_wdata_i),
         .preset_word_o(preset_words[k*REG_W +: REG_W]),
         .status_word_o(status_words[k*REG_W +: REG_W]),
         .irq_o(irq_o[k])
      );
   end

   tick_cdt_rdmux #(.NUM_CH(NUM_CH)) u_rdmux (
      .ch_sel_i(ch_sel), .reg_sel_i(reg_sel),
      .preset_words_i(preset_words), .status_words_i(status_words),
      .rdata_o(bus_rdata_o)
   );

   // R1: interrupts are quiet in the first cycle out of reset
   assert_reset_quiet_R1: assert property (@(posedge clk)
      !rst_n |=> (irq_o == '0));
endmodule

// File: tb/tick_cdt_bank_bench.sv
module tick_cdt_bank_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_i = 1'b0;
   logic        bus_we_i = 1'b0;
   logic [7:0]  bus_addr_i = 8'h00;
   logic [31:0] bus_wdata_i = 32'h0;
   logic [31:0] bus_rdata_o;
   logic [3:0]  irq_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #10 clk = ~clk;

   tick_cdt_bank u_tick_cdt_bank (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .bus_we_i(bus_we_i),
      .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i),
      .bus_rdata_o(bus_rdata_o), .irq_o(irq_o)
   );

   function automatic logic [7:0] pre_a(input int ch);
      return 8'(8'h50 + 8 * ch);
   endfunction
   function automatic logic [7:0] sta_a(input int ch);
      return 8'(8'h54 + 8 * ch);
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      bus_we_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
      @(negedge clk);
      bus_we_i = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      bus_addr_i = a;
      #1 d = bus_rdata_o;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         tick_i = 1'b1;
         @(negedge clk);
      end
      tick_i = 1'b0;
   endtask

   // vector: channel, repeat flag, load N, expected ticks to expiry
   localparam logic [47:0] VEC [6] = '{
      {8'd0, 8'd0, 16'd0,  16'd1},
      {8'd1, 8'd0, 16'd1,  16'd2},
      {8'd2, 8'd1, 16'd2,  16'd3},
      {8'd3, 8'd0, 16'd5,  16'd6},
      {8'd0, 8'd1, 16'd13, 16'd14},
      {8'd3, 8'd1, 16'd0,  16'd1}
   };

   initial begin
      #(20 * 100000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk(irq_o == 4'h0, "R1 irq", 32'(irq_o), 0);
      rd(pre_a(2), d); chk(d == 0, "R1 preset", d, 0);
      rd(sta_a(3), d); chk(d == 0, "R1 status", d, 0);

      // R3 table walk
      for (int v = 0; v < 6; v++) begin
         int ch, rep, n, ex;
         ch = int'(VEC[v][47:40]); rep = int'(VEC[v][39:32]);
         n = int'(VEC[v][31:16]);  ex = int'(VEC[v][15:0]);
         wr(pre_a(ch), 32'h8000_0000 | (rep != 0 ? 32'h4000_0000 : 0) | 32'(n));
         ticks(ex - 1);
         chk(irq_o[ch] == 1'b0, "R3 early", 32'(irq_o), 0);
         ticks(1);
         chk(irq_o[ch] == 1'b1, "R3 expiry", 32'(irq_o), 32'(1 << ch));
         wr(sta_a(ch), 32'h4000_0000);
         chk(irq_o[ch] == 1'b0, "R7 clear", 32'(irq_o), 0);
         wr(pre_a(ch), 0);
      end

      // R2 restart while running
      wr(pre_a(0), 32'h8000_0064);
      ticks(3);
      rd(sta_a(0), d); chk(d == 32'd97, "R2 running count", d, 97);
      tick_i = 1'b1;
      wr(pre_a(0), 32'h8000_0005);
      tick_i = 1'b0;
      rd(sta_a(0), d); chk(d == 32'd5, "R2 restart", d, 5);
      // R10 hold without tick
      repeat (10) @(negedge clk);
      rd(sta_a(0), d); chk(d == 32'd5, "R10 hold", d, 5);

      // R6 stop by writing 0
      ticks(2);
      wr(pre_a(0), 0);
      ticks(8);
      rd(sta_a(0), d); chk(d == 0, "R6 count", d, 0);
      chk(irq_o[0] == 1'b0, "R6 irq", 32'(irq_o), 0);

      // R4 repeat mode
      wr(pre_a(1), 32'hC000_0002);
      ticks(3);
      chk(irq_o[1] == 1'b1, "R4 first", 32'(irq_o), 2);
      rd(sta_a(1), d); chk(d == 32'h4000_0002, "R4 reload + R9 status", d, 32'h4000_0002);
      wr(sta_a(1), 32'h0000_0000);
      chk(irq_o[1] == 1'b1, "R7 no-ack write", 32'(irq_o), 2);
      repeat (5) @(negedge clk);
      chk(irq_o[1] == 1'b1, "R11 level", 32'(irq_o), 2);
      wr(sta_a(1), 32'h4000_0000);
      ticks(2);
      chk(irq_o[1] == 1'b0, "R4 mid", 32'(irq_o), 0);
      ticks(1);
      chk(irq_o[1] == 1'b1, "R4 second", 32'(irq_o), 2);
      rd(pre_a(1), d); chk(d == 32'hC000_0002, "R4 enable kept", d, 32'hC000_0002);
      wr(pre_a(1), 0);
      wr(sta_a(1), 32'h4000_0000);

      // R5 single mode
      wr(pre_a(2), 32'h8000_0001);
      ticks(2);
      chk(irq_o[2] == 1'b1, "R5 expiry", 32'(irq_o), 4);
      rd(pre_a(2), d); chk(d == 32'h0000_0001, "R5 enable dropped", d, 1);
      wr(sta_a(2), 32'h4000_0000);
      ticks(10);
      chk(irq_o[2] == 1'b0, "R5 no rerun", 32'(irq_o), 0);

      // R8 expiry and clear in the same cycle
      wr(pre_a(2), 32'hC000_0000);
      ticks(1);
      chk(irq_o[2] == 1'b1, "R8 setup", 32'(irq_o), 4);
      tick_i = 1'b1;
      wr(sta_a(2), 32'h4000_0000);
      tick_i = 1'b0;
      chk(irq_o[2] == 1'b1, "R8 expiry wins", 32'(irq_o), 4);
      wr(pre_a(2), 32'hC000_0003);
      tick_i = 1'b1;
      wr(sta_a(2), 32'h4000_0000);
      tick_i = 1'b0;
      chk(irq_o[2] == 1'b0, "R8 clear without expiry", 32'(irq_o), 0);
      wr(pre_a(2), 0);

      // R12 unmapped addresses
      wr(pre_a(3), 32'h8000_0009);
      wr(8'h48, 32'hFFFF_FFFF);
      wr(8'h70, 32'hFFFF_FFFF);
      wr(8'h6A, 32'hFFFF_FFFF);
      wr(8'h5C + 8'h2, 32'hFFFF_FFFF);
      rd(sta_a(3), d); chk(d == 32'd9, "R12 neighbour count", d, 9);
      rd(pre_a(0), d); chk(d == 0, "R12 ch0 untouched", d, 0);
      rd(pre_a(1), d); chk(d == 0, "R12 ch1 untouched", d, 0);
      chk(irq_o == 4'h0, "R12 irq", 32'(irq_o), 0);
      rd(8'h70, d); chk(d == 0, "R12 read outside", d, 0);
      rd(8'h52, d); chk(d == 0, "R12 read gap", d, 0);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule